// File: doc/BRIEF.md
# Scheduled Command Outcome Controller

This block decides the fate of a scheduled transmit command after each attempt at it. When a command is loaded, its control bits are captured: the retry limit, how a bandwidth shortfall is treated, the pause policies for burst and non-burst commands, whether a requeue counts as a pause, and the burst continuation with its interframe-space choice. The same load also captures whether the exchange expects a response, and which command-ring timers to restart. Each attempt then reports one of four results: success, no response, bandwidth failure or requeue. The controller answers each result one cycle later with a single action pulse.

The action is one of seven: done, retry, filter, pause, new backoff, next command after SIFS, or next command after PIFS. The controller also keeps a count of the tries the command has used. It flags a filter or pause that comes from running out of retries. It pulses restart strobes for the command-ring timers. The controller neither transmits frames nor runs the timers. A host scheduler loads a command, launches attempts and acts on the returned pulses. Once a pulse ends the command, the controller ignores further results until the next load.

Top module: `txcmd_outcome_ctl`

## Requirements
- R1: A load pulse clears the try count to 0 and captures all command controls. Attempt results that arrive in the same cycle as the load are ignored, and no action follows them.
- R2: While a command is active, every cycle with at least one result strobe is followed in the next cycle by exactly one action pulse. A cycle with no strobe, or with no active command, is followed by no action pulse.
- R3: When several result strobes arrive in the same cycle, only one is handled. Success wins over bandwidth failure, bandwidth failure wins over requeue, and requeue wins over no response.
- R4: A successful attempt gives next-after-SIFS when burst continuation is set and the interframe-space bit is 0. It gives next-after-PIFS when burst continuation is set and that bit is 1. Without burst continuation, it gives pause if stall-enable is set, and done otherwise.
- R5: A no-response result, when a response is expected, increments the try count. If the new count is still below the retry limit, the action is retry. Once the new count reaches the limit, the command takes the filter path and the exhausted flag pulses with the action.
- R6: When no response is expected, a no-response result is handled as a success. The retry limit and the try count play no part.
- R7: A bandwidth failure takes the filter path when the filter-on-bandwidth-failure bit is set. When the bit is clear, it gives new backoff. In neither case does the try count change.
- R8: On the filter path, the action is pause when the command has burst continuation and pause-on-filter set. Otherwise the action is filter.
- R9: A requeue result gives pause when requeue-as-pause is set, and new backoff otherwise. The try count does not change.
- R10: For each command-ring timer whose first-evaluation restart bit is set at load, a restart pulse appears in the cycle after the load.
- R11: For each timer whose after-success restart bit was captured, a restart pulse appears together with the action of a success outcome, including one produced under R6. Failure outcomes give no restart pulse.
- R12: Done, filter, pause, next-after-SIFS and next-after-PIFS end the command. Retry and new backoff keep it active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Load a new command and capture its controls |
| cmd_retry_lim | input | TRY_W | Maximum number of tries |
| cmd_bw_filter | input | 1 | Filter the command on a bandwidth failure |
| cmd_pause_on_filt | input | 1 | Pause instead of filter inside a burst |
| cmd_stall_en | input | 1 | Pause after success for a non-burst command |
| cmd_requeue_pause | input | 1 | Treat a requeue as a pause |
| cmd_burst_cont | input | 1 | The command is followed by a burst continuation |
| cmd_ifs_pifs | input | 1 | Interframe space for the continuation: 0 SIFS, 1 PIFS |
| cmd_expect_resp | input | 1 | The exchange expects a response frame |
| cmd_tmr_first | input | NTMR | Per-timer restart at first evaluation |
| cmd_tmr_after | input | NTMR | Per-timer restart after success |
| att_success | input | 1 | Attempt result: success |
| att_no_resp | input | 1 | Attempt result: no response received |
| att_bw_fail | input | 1 | Attempt result: bandwidth failure |
| att_requeue | input | 1 | Attempt result: requeue |
| out_done | output | 1 | Action pulse: command done |
| out_retry | output | 1 | Action pulse: retry |
| out_filter | output | 1 | Action pulse: filter |
| out_pause | output | 1 | Action pulse: pause |
| out_backoff | output | 1 | Action pulse: new backoff |
| out_next_sifs | output | 1 | Action pulse: start next command after SIFS |
| out_next_pifs | output | 1 | Action pulse: start next command after PIFS |
| out_exhausted | output | 1 | Retries exhausted, with a filter or pause pulse |
| out_tmr_restart | output | NTMR | Command-ring timer restart pulses |
| try_count | output | TRY_W | Tries used by the current command |

## Verification
On every cycle, the assertions check the following properties. Each result strobe on an active command gets exactly one action, and quiet or idle cycles give none. A load clears the try count. A quiet bandwidth failure gives new backoff and leaves the count unchanged. The exhausted flag never appears without a filter or pause. Every first-evaluation restart bit is answered by a pulse. Only the directed scenarios show which action the outcome mapping chooses for each combination of controls. They also cover the retry limit reached at the right try, the strobe priority, the success restarts, and the commands that go silent after a terminal action.

// File: rtl/txcmd_outcome_pkg.sv
package txcmd_outcome_pkg;

  typedef struct packed {
    logic bw_filter;
    logic pause_on_filt;
    logic stall_en;
    logic requeue_pause;
    logic burst_cont;
    logic ifs_pifs;
    logic expect_resp;
  } cmd_flags_t;

  typedef enum logic [2:0] {
    ACT_NONE      = 3'd0,
    ACT_DONE      = 3'd1,
    ACT_RETRY     = 3'd2,
    ACT_FILTER    = 3'd3,
    ACT_PAUSE     = 3'd4,
    ACT_BACKOFF   = 3'd5,
    ACT_NEXT_SIFS = 3'd6,
    ACT_NEXT_PIFS = 3'd7
  } act_e;

  localparam int NUM_ACT = 8;

  // Actions after which the command is no longer live.
  function automatic logic act_ends(act_e a);
    return (a != ACT_NONE) && (a != ACT_RETRY) && (a != ACT_BACKOFF);
  endfunction

endpackage

// File: rtl/txcmd_rst_sync.sv
module txcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/txcmd_try_cnt.sv
module txcmd_try_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                   cnt_d = '0;
    else if (inc && cnt != '1) cnt_d = cnt + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/txcmd_outcome_dec.sv
module txcmd_outcome_dec
  import txcmd_outcome_pkg::*;
#(
  parameter int TRY_W = 4
) (
  input  logic             live,
  input  cmd_flags_t       flags,
  input  logic [TRY_W-1:0] lim,
  input  logic [TRY_W-1:0] try_cnt,
  input  logic             success,
  input  logic             no_resp,
  input  logic             bw_fail,
  input  logic             requeue,
  output act_e             act,
  output logic             try_inc,
  output logic             exhausted,
  output logic             ok
);
  logic [TRY_W:0] try_next;
  logic           filt_path;

  assign try_next = {1'b0, try_cnt} + {{TRY_W{1'b0}}, 1'b1};

  always_comb begin
    act       = ACT_NONE;
    try_inc   = 1'b0;
    exhausted = 1'b0;
    ok        = 1'b0;
    filt_path = 1'b0;
    if (live) begin
      if (success) begin
        ok = 1'b1;
      end else if (bw_fail) begin
        if (flags.bw_filter) filt_path = 1'b1;
        else                 act = ACT_BACKOFF;
      end else if (requeue) begin
        act = flags.requeue_pause ? ACT_PAUSE : ACT_BACKOFF;
      end else if (no_resp) begin
        if (!flags.expect_resp) begin
          ok = 1'b1;
        end else begin
          try_inc = 1'b1;
          if (try_next >= {1'b0, lim}) begin
            exhausted = 1'b1;
            filt_path = 1'b1;
          end else begin
            act = ACT_RETRY;
          end
        end
      end
      if (ok) begin
        if (flags.burst_cont) act = flags.ifs_pifs ? ACT_NEXT_PIFS : ACT_NEXT_SIFS;
        else                  act = flags.stall_en ? ACT_PAUSE : ACT_DONE;
      end
      if (filt_path) begin
        act = (flags.burst_cont && flags.pause_on_filt) ? ACT_PAUSE : ACT_FILTER;
      end
    end
  end
endmodule

// File: rtl/txcmd_outcome_ctl.sv
module txcmd_outcome_ctl
  import txcmd_outcome_pkg::*;
#(
  parameter int TRY_W = 4,
  parameter int NTMR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_load,
  input  logic [TRY_W-1:0] cmd_retry_lim,
  input  logic             cmd_bw_filter,
  input  logic             cmd_pause_on_filt,
  input  logic             cmd_stall_en,
  input  logic             cmd_requeue_pause,
  input  logic             cmd_burst_cont,
  input  logic             cmd_ifs_pifs,
  input  logic             cmd_expect_resp,
  input  logic [NTMR-1:0]  cmd_tmr_first,
  input  logic [NTMR-1:0]  cmd_tmr_after,
  input  logic             att_success,
  input  logic             att_no_resp,
  input  logic             att_bw_fail,
  input  logic             att_requeue,
  output logic             out_done,
  output logic             out_retry,
  output logic             out_filter,
  output logic             out_pause,
  output logic             out_backoff,
  output logic             out_next_sifs,
  output logic             out_next_pifs,
  output logic             out_exhausted,
  output logic [NTMR-1:0]  out_tmr_restart,
  output logic [TRY_W-1:0] try_count
);
  logic             rst_q_n;
  cmd_flags_t       flags_q, cmd_flags;
  logic [TRY_W-1:0] lim_q;
  logic [NTMR-1:0]  tafter_q;
  logic             active_q, active_d;
  act_e             act_q, act_d;
  logic             exh_q, exh_d;
  logic [NTMR-1:0]  tmr_q, tmr_d;
  act_e             dec_act;
  logic             dec_inc, dec_exh, dec_ok, live;
  logic [NUM_ACT-1:0] act_oh;

  txcmd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  always_comb begin
    cmd_flags.bw_filter     = cmd_bw_filter;
    cmd_flags.pause_on_filt = cmd_pause_on_filt;
    cmd_flags.stall_en      = cmd_stall_en;
    cmd_flags.requeue_pause = cmd_requeue_pause;
    cmd_flags.burst_cont    = cmd_burst_cont;
    cmd_flags.ifs_pifs      = cmd_ifs_pifs;
    cmd_flags.expect_resp   = cmd_expect_resp;
  end

  // Command controls: captured only on load (clock enable).
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flags_q  <= '0;
      lim_q    <= '0;
      tafter_q <= '0;
    end else if (cmd_load) begin
      flags_q  <= cmd_flags;
      lim_q    <= cmd_retry_lim;
      tafter_q <= cmd_tmr_after;
    end
  end

  assign live = active_q && !cmd_load;

  txcmd_outcome_dec #(.TRY_W(TRY_W)) u_dec (
    .live(live), .flags(flags_q), .lim(lim_q), .try_cnt(try_count),
    .success(att_success), .no_resp(att_no_resp),
    .bw_fail(att_bw_fail), .requeue(att_requeue),
    .act(dec_act), .try_inc(dec_inc), .exhausted(dec_exh), .ok(dec_ok)
  );

  txcmd_try_cnt #(.W(TRY_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .clr(cmd_load), .inc(dec_inc), .cnt(try_count)
  );

  always_comb begin
    act_d    = dec_act;
    exh_d    = dec_exh;
    active_d = cmd_load || (active_q && !act_ends(dec_act));
    if (cmd_load)    tmr_d = cmd_tmr_first;
    else if (dec_ok) tmr_d = tafter_q;
    else             tmr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      active_q <= 1'b0;
      act_q    <= ACT_NONE;
      exh_q    <= 1'b0;
      tmr_q    <= '0;
    end else begin
      active_q <= active_d;
      act_q    <= act_d;
      exh_q    <= exh_d;
      tmr_q    <= tmr_d;
    end
  end

  for (genvar k = 0; k < NUM_ACT; k++) begin : g_oh
    assign act_oh[k] = (act_q == act_e'(k));
  end

  assign out_done        = act_oh[ACT_DONE];
  assign out_retry       = act_oh[ACT_RETRY];
  assign out_filter      = act_oh[ACT_FILTER];
  assign out_pause       = act_oh[ACT_PAUSE];
  assign out_backoff     = act_oh[ACT_BACKOFF];
  assign out_next_sifs   = act_oh[ACT_NEXT_SIFS];
  assign out_next_pifs   = act_oh[ACT_NEXT_PIFS];
  assign out_exhausted   = exh_q;
  assign out_tmr_restart = tmr_q;
endmodule

// File: rtl/txcmd_outcome_chk.sv
module txcmd_outcome_chk #(
  parameter int TRY_W = 4,
  parameter int NTMR  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_load,
  input logic [NTMR-1:0]  cmd_tmr_first,
  input logic             att_success,
  input logic             att_no_resp,
  input logic             att_bw_fail,
  input logic             att_requeue,
  input logic             active_q,
  input logic             bw_filter_q,
  input logic [6:0]       acts,
  input logic             out_exhausted,
  input logic             out_backoff,
  input logic [NTMR-1:0]  out_tmr_restart,
  input logic [TRY_W-1:0] try_count
);
  logic any_res, handled;
  assign any_res = att_success | att_no_resp | att_bw_fail | att_requeue;
  assign handled = active_q && !cmd_load && any_res;

  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handled |=> ($countones(acts) == 1));

  // R2
  quiet_no_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !handled |=> (acts == 7'd0));

  // R1
  load_clears_try_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> (try_count == '0));

  // R7
  quiet_bw_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cmd_load && att_bw_fail && !att_success && !bw_filter_q)
    |=> (out_backoff && $stable(try_count)));

  // R5
  exhausted_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_exhausted |-> (acts[4] || acts[3]));

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    // R10
    first_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && cmd_tmr_first[i]) |=> out_tmr_restart[i]);
  end
endmodule

bind txcmd_outcome_ctl txcmd_outcome_chk #(.TRY_W(TRY_W), .NTMR(NTMR)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .cmd_load(cmd_load), .cmd_tmr_first(cmd_tmr_first),
  .att_success(att_success), .att_no_resp(att_no_resp),
  .att_bw_fail(att_bw_fail), .att_requeue(att_requeue),
  .active_q(active_q), .bw_filter_q(flags_q.bw_filter),
  .acts({out_done, out_retry, out_filter, out_pause, out_backoff, out_next_sifs, out_next_pifs}),
  .out_exhausted(out_exhausted), .out_backoff(out_backoff),
  .out_tmr_restart(out_tmr_restart), .try_count(try_count)
);

// File: tb/txcmd_outcome_ctl_test.sv
module txcmd_outcome_ctl_test;
  localparam int TRY_W = 4;
  localparam int NTMR  = 2;

  localparam logic [6:0] A_NONE  = 7'b0000000;
  localparam logic [6:0] A_DONE  = 7'b1000000;
  localparam logic [6:0] A_RETRY = 7'b0100000;
  localparam logic [6:0] A_FILT  = 7'b0010000;
  localparam logic [6:0] A_PAUSE = 7'b0001000;
  localparam logic [6:0] A_BOFF  = 7'b0000100;
  localparam logic [6:0] A_SIFS  = 7'b0000010;
  localparam logic [6:0] A_PIFS  = 7'b0000001;

  logic clk, rst_n;
  logic cmd_load;
  logic [TRY_W-1:0] cmd_retry_lim;
  logic cmd_bw_filter, cmd_pause_on_filt, cmd_stall_en, cmd_requeue_pause;
  logic cmd_burst_cont, cmd_ifs_pifs, cmd_expect_resp;
  logic [NTMR-1:0] cmd_tmr_first, cmd_tmr_after;
  logic att_success, att_no_resp, att_bw_fail, att_requeue;
  logic out_done, out_retry, out_filter, out_pause, out_backoff, out_next_sifs, out_next_pifs;
  logic out_exhausted;
  logic [NTMR-1:0] out_tmr_restart;
  logic [TRY_W-1:0] try_count;
  logic [6:0] acts;

  int checks = 0;
  int errors = 0;

  txcmd_outcome_ctl #(.TRY_W(TRY_W), .NTMR(NTMR)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_retry_lim(cmd_retry_lim),
    .cmd_bw_filter(cmd_bw_filter), .cmd_pause_on_filt(cmd_pause_on_filt),
    .cmd_stall_en(cmd_stall_en), .cmd_requeue_pause(cmd_requeue_pause),
    .cmd_burst_cont(cmd_burst_cont), .cmd_ifs_pifs(cmd_ifs_pifs),
    .cmd_expect_resp(cmd_expect_resp), .cmd_tmr_first(cmd_tmr_first),
    .cmd_tmr_after(cmd_tmr_after), .att_success(att_success),
    .att_no_resp(att_no_resp), .att_bw_fail(att_bw_fail), .att_requeue(att_requeue),
    .out_done(out_done), .out_retry(out_retry), .out_filter(out_filter),
    .out_pause(out_pause), .out_backoff(out_backoff), .out_next_sifs(out_next_sifs),
    .out_next_pifs(out_next_pifs), .out_exhausted(out_exhausted),
    .out_tmr_restart(out_tmr_restart), .try_count(try_count)
  );

  assign acts = {out_done, out_retry, out_filter, out_pause, out_backoff, out_next_sifs, out_next_pifs};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [TRY_W-1:0] lim, input logic bwf, input logic pof,
                         input logic stall, input logic rqp, input logic burst,
                         input logic pifs, input logic expr,
                         input logic [NTMR-1:0] tf, input logic [NTMR-1:0] ta);
    cmd_retry_lim = lim; cmd_bw_filter = bwf; cmd_pause_on_filt = pof;
    cmd_stall_en = stall; cmd_requeue_pause = rqp; cmd_burst_cont = burst;
    cmd_ifs_pifs = pifs; cmd_expect_resp = expr; cmd_tmr_first = tf; cmd_tmr_after = ta;
  endtask

  task automatic do_load(input string req);
    @(negedge clk) cmd_load = 1'b1;
    @(negedge clk) cmd_load = 1'b0;
    check(req, {9'd0, acts}, {9'd0, A_NONE});
    check(req, {12'd0, try_count}, 16'd0);
    check(req, {14'd0, out_tmr_restart}, {14'd0, cmd_tmr_first});
  endtask

  task automatic strobe(input logic s, input logic n, input logic b, input logic r);
    @(negedge clk) begin
      att_success = s; att_no_resp = n; att_bw_fail = b; att_requeue = r;
    end
    @(negedge clk) begin
      att_success = 0; att_no_resp = 0; att_bw_fail = 0; att_requeue = 0;
    end
  endtask

  task automatic expect_out(input string req, input logic [6:0] a, input logic [TRY_W-1:0] t,
                            input logic e, input logic [NTMR-1:0] tm);
    check(req, {9'd0, acts}, {9'd0, a});
    check(req, {12'd0, try_count}, {12'd0, t});
    check(req, {15'd0, out_exhausted}, {15'd0, e});
    check(req, {14'd0, out_tmr_restart}, {14'd0, tm});
  endtask

  task automatic t_reset_and_idle();
    expect_out("R2 reset state", A_NONE, 0, 0, 2'b00);
    strobe(1, 1, 1, 1);
    expect_out("R2 idle strobe ignored", A_NONE, 0, 0, 2'b00);
  endtask

  task automatic t_success_done();
    set_cfg(3, 0, 0, 0, 0, 0, 0, 1, 2'b01, 2'b10);
    do_load("R10 first-evaluation restart");
    strobe(1, 0, 0, 0);
    expect_out("R11 R4 success done", A_DONE, 0, 0, 2'b10);
    strobe(1, 0, 0, 0);
    expect_out("R12 ended command silent", A_NONE, 0, 0, 2'b00);
  endtask

  task automatic t_success_variants();
    set_cfg(3, 0, 0, 1, 0, 1, 0, 1, 2'b00, 2'b00);
    do_load("R1 load burst sifs");
    strobe(1, 0, 0, 0);
    expect_out("R4 burst sifs (stall ignored)", A_SIFS, 0, 0, 2'b00);
    set_cfg(3, 0, 0, 0, 0, 1, 1, 1, 2'b00, 2'b00);
    do_load("R1 load burst pifs");
    strobe(1, 0, 0, 0);
    expect_out("R4 burst pifs", A_PIFS, 0, 0, 2'b00);
    set_cfg(3, 0, 0, 1, 0, 0, 0, 1, 2'b00, 2'b00);
    do_load("R1 load stall");
    strobe(1, 0, 0, 0);
    expect_out("R4 stall pause", A_PAUSE, 0, 0, 2'b00);
  endtask

  task automatic t_retry_limit();
    set_cfg(3, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b11);
    do_load("R1 load retry");
    strobe(0, 1, 0, 0);
    expect_out("R5 R11 retry 1", A_RETRY, 1, 0, 2'b00);
    strobe(0, 1, 0, 0);
    expect_out("R5 R12 retry 2", A_RETRY, 2, 0, 2'b00);
    strobe(0, 1, 0, 0);
    expect_out("R5 exhausted filter", A_FILT, 3, 1, 2'b00);
    strobe(0, 1, 0, 0);
    expect_out("R12 after filter silent", A_NONE, 3, 0, 2'b00);
  endtask

  task automatic t_pause_on_filter();
    set_cfg(1, 0, 1, 0, 0, 1, 0, 1, 2'b00, 2'b00);
    do_load("R1 load pause-on-filter");
    strobe(0, 1, 0, 0);
    expect_out("R8 burst exhausted pause", A_PAUSE, 1, 1, 2'b00);
  endtask

  task automatic t_bw_fail();
    set_cfg(5, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00);
    do_load("R1 load bw quiet");
    strobe(0, 1, 0, 0);
    expect_out("R5 retry before bw", A_RETRY, 1, 0, 2'b00);
    strobe(0, 0, 1, 0);
    expect_out("R7 quiet collision backoff", A_BOFF, 1, 0, 2'b00);
    strobe(0, 1, 0, 0);
    expect_out("R12 still active after backoff", A_RETRY, 2, 0, 2'b00);
    set_cfg(5, 1, 0, 0, 0, 1, 0, 1, 2'b00, 2'b00);
    do_load("R1 load bw filter");
    strobe(0, 0, 1, 0);
    expect_out("R7 R8 bw filter", A_FILT, 0, 0, 2'b00);
  endtask

  task automatic t_requeue();
    set_cfg(5, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00);
    do_load("R1 load requeue");
    strobe(0, 0, 0, 1);
    expect_out("R9 requeue backoff", A_BOFF, 0, 0, 2'b00);
    set_cfg(5, 0, 0, 0, 1, 0, 0, 1, 2'b00, 2'b00);
    do_load("R1 load requeue pause");
    strobe(0, 0, 0, 1);
    expect_out("R9 requeue as pause", A_PAUSE, 0, 0, 2'b00);
  endtask

  task automatic t_no_resp_unexpected();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b01);
    do_load("R1 load no-response-expected");
    strobe(0, 1, 0, 0);
    expect_out("R6 R11 limit ignored", A_DONE, 0, 0, 2'b01);
  endtask

  task automatic t_priority();
    set_cfg(1, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00);
    do_load("R1 load priority");
    strobe(0, 1, 1, 1);
    expect_out("R3 bw over requeue and no-resp", A_BOFF, 0, 0, 2'b00);
    strobe(0, 1, 0, 1);
    expect_out("R3 requeue over no-resp", A_BOFF, 0, 0, 2'b00);
    strobe(1, 1, 1, 1);
    expect_out("R3 success first", A_DONE, 0, 0, 2'b00);
  endtask

  task automatic t_load_collision();
    set_cfg(2, 0, 0, 0, 0, 0, 0, 1, 2'b10, 2'b00);
    @(negedge clk) begin cmd_load = 1'b1; att_success = 1'b1; end
    @(negedge clk) begin cmd_load = 1'b0; att_success = 1'b0; end
    expect_out("R1 strobe in load cycle ignored", A_NONE, 0, 0, 2'b10);
    strobe(0, 1, 0, 0);
    expect_out("R1 command live after load", A_RETRY, 1, 0, 2'b00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_load = 1'b0;
    att_success = 0; att_no_resp = 0; att_bw_fail = 0; att_requeue = 0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_and_idle();
    t_success_done();
    t_success_variants();
    t_retry_limit();
    t_pause_on_filter();
    t_bw_fail();
    t_requeue();
    t_no_resp_unexpected();
    t_priority();
    t_load_collision();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule